// File: doc/BRIEF.md
# Eight-Channel PWM LED Dimmer and Blinker

This block switches a row of LED enable lines, eight by default, each under its own brightness code. A shared fast counter advances once per prescaler tick. A channel is lit while that counter is below the channel's 8-bit code, which gives a fixed-frequency PWM with 256 steps. A second and much slower group gate is ANDed onto every channel. The group gate does not replace the per-channel duty. It runs in one of two modes, picked at run time. In dimming mode it is a slow PWM that steps once per fast period. In blinking mode it is an on/off pattern whose length and on-fraction are both programmable.

The system clock stands in for the oscillator, and a clock-enable prescaler sets the fast PWM rate. A sleep input halts all counters and blanks the outputs. When sleep is released, a wake timer holds the outputs dark until the time base can be trusted again. An active-low enable pin blanks every output at once. The configuration inputs are driven by the surrounding logic and are never cleared by this block.

Top module: `led_dimmer_top`

## Requirements
- R1: While rst_ni is low, led_o is all zero. After reset the wake timer starts at zero, exactly as it does after a sleep release (R9).
- R2: When its output is enabled and the group gate is open, channel i is lit exactly when the fast counter is below byte i of bright_i, where byte i is bits [8i+7:8i]. A code of 0 keeps the channel dark. A new code takes effect in the same cycle.
- R3: While running, the fast counter advances by one every DIV clock cycles and wraps from 255 to 0. A channel with code c is lit for c*DIV cycles out of every 256*DIV.
- R4: When blink_mode_i is 0, a group step counter advances on every fast-counter wrap and wraps at 256. The gate is open while that counter is below grp_duty_i.
- R5: When blink_mode_i is 1, a phase counter advances once every BLINK_BASE fast periods. It returns to 0 on the step at which it has reached or passed grp_period_i, so the cycle lasts (grp_period_i+1)*BLINK_BASE fast periods. The gate is open while phase*256 < grp_duty_i*(grp_period_i+1).
- R6: When blink_mode_i is 0, grp_period_i has no effect on led_o.
- R7: While oe_ni is high, led_o is all zero in the same cycle. While oe_ni is low, the outputs follow R2.
- R8: After a clock edge at which sleep_i is high, led_o is zero and all counters are cleared.
- R9: After sleep_i falls, the wake timer takes WAKE_CYC clock edges to reach its limit. The outputs stay dark and the counters stay at zero until then. The counters start advancing at the edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bright_i | input | 8*N_CH | Brightness codes, byte i for channel i |
| grp_duty_i | input | 8 | Group dimming duty or blink on-fraction |
| grp_period_i | input | 8 | Blink period in base intervals, minus one |
| blink_mode_i | input | 1 | 1 selects blinking, 0 selects dimming |
| sleep_i | input | 1 | Halts the time base and blanks the outputs |
| oe_ni | input | 1 | Output enable, active low |
| led_o | output | N_CH | LED enable lines |

## Verification
The outputs are combinational from registered counters and the current inputs. A change in brightness, group duty, period, mode or oe_ni therefore appears within the same cycle, and the bench samples led_o at the falling edge that follows each input change. Sleep and wake act through registers, so their effect is expected one edge after the stimulus. The bench keeps its own cycle-level model of the prescaler, the wake timer and both group counters. That model advances on each rising edge, and every falling-edge comparison uses the state held after that edge. A directed run counts lit cycles across exactly one fast period to confirm the duty, and randomized phases cover the mode switches, period changes and sleep cycles.

// File: rtl/led_dimmer_pkg.sv
package led_dimmer_pkg;
  localparam int unsigned BR_W = 8;
  typedef logic [BR_W-1:0] code_t;
endpackage

// File: rtl/led_timebase.sv
module led_timebase #(
  parameter int unsigned DIV      = 4,
  parameter int unsigned WAKE_CYC = 12500
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sleep_i,
  output logic                      ready_o,
  output logic                      run_o,
  output logic                      tick_o,
  output logic                      wrap_o,
  output led_dimmer_pkg::code_t     cnt_o
);
  import led_dimmer_pkg::*;
  localparam int unsigned PRE_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned WAKE_W = $clog2(WAKE_CYC + 1);
  localparam logic [WAKE_W-1:0] WAKE_LIM = WAKE_W'(WAKE_CYC);
  localparam logic [PRE_W-1:0]  PRE_LIM  = PRE_W'(DIV - 1);

  logic [WAKE_W-1:0] wake_q;
  logic [PRE_W-1:0]  pre_q;
  code_t             cnt_q;

  assign ready_o = (wake_q == WAKE_LIM);
  assign run_o   = ready_o & ~sleep_i;
  assign tick_o  = run_o & (pre_q == PRE_LIM);
  assign wrap_o  = tick_o & (&cnt_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 wake_q <= '0;
    else if (sleep_i)            wake_q <= '0;
    else if (wake_q != WAKE_LIM) wake_q <= wake_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_o) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_group_gate.sv
module led_group_gate #(
  parameter int unsigned BLINK_BASE = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  wrap_i,
  input  led_dimmer_pkg::code_t duty_i,
  input  led_dimmer_pkg::code_t period_i,
  input  logic                  blink_mode_i,
  output logic                  gate_o
);
  import led_dimmer_pkg::*;
  localparam int unsigned BP_W  = (BLINK_BASE > 1) ? $clog2(BLINK_BASE) : 1;
  localparam int unsigned PRD_W = 2 * BR_W + 1;
  localparam logic [BP_W-1:0] BP_LIM = BP_W'(BLINK_BASE - 1);

  code_t           dim_q, phase_q;
  logic [BP_W-1:0] bpre_q;
  logic            base_step;
  logic [PRD_W-1:0] phase_scaled, on_limit;

  assign base_step = wrap_i & (bpre_q == BP_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dim_q   <= '0;
      bpre_q  <= '0;
      phase_q <= '0;
    end else if (!run_i) begin
      dim_q   <= '0;
      bpre_q  <= '0;
      phase_q <= '0;
    end else if (wrap_i) begin
      dim_q  <= dim_q + 1'b1;
      bpre_q <= base_step ? '0 : bpre_q + 1'b1;
      if (base_step) phase_q <= (phase_q >= period_i) ? '0 : phase_q + 1'b1;
    end
  end

  // cross-multiplied on-fraction test: phase/(period+1) < duty/256
  assign phase_scaled = {1'b0, phase_q, {BR_W{1'b0}}};
  assign on_limit     = PRD_W'(duty_i) * (PRD_W'(period_i) + PRD_W'(1));

  always_comb begin
    if (blink_mode_i) gate_o = phase_scaled < on_limit;
    else              gate_o = dim_q < duty_i;
  end
endmodule

// File: rtl/led_channel.sv
module led_channel (
  input  led_dimmer_pkg::code_t cnt_i,
  input  led_dimmer_pkg::code_t bright_i,
  input  logic                  gate_i,
  input  logic                  en_i,
  output logic                  led_o
);
  assign led_o = en_i & gate_i & (cnt_i < bright_i);
endmodule

// File: rtl/led_dimmer_top.sv
module led_dimmer_top #(
  parameter int unsigned N_CH       = 8,
  parameter int unsigned DIV        = 4,
  parameter int unsigned BLINK_BASE = 4,
  parameter int unsigned WAKE_CYC   = 12500
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [N_CH*led_dimmer_pkg::BR_W-1:0]   bright_i,
  input  logic [led_dimmer_pkg::BR_W-1:0]        grp_duty_i,
  input  logic [led_dimmer_pkg::BR_W-1:0]        grp_period_i,
  input  logic                                   blink_mode_i,
  input  logic                                   sleep_i,
  input  logic                                   oe_ni,
  output logic [N_CH-1:0]                        led_o
);
  import led_dimmer_pkg::*;

  logic  ready, run, tick, wrap, gate, en;
  code_t cnt;

  led_timebase #(.DIV(DIV), .WAKE_CYC(WAKE_CYC)) u_tb (
    .clk_i, .rst_ni, .sleep_i,
    .ready_o(ready), .run_o(run), .tick_o(tick), .wrap_o(wrap), .cnt_o(cnt)
  );

  led_group_gate #(.BLINK_BASE(BLINK_BASE)) u_grp (
    .clk_i, .rst_ni, .run_i(run), .wrap_i(wrap),
    .duty_i(grp_duty_i), .period_i(grp_period_i),
    .blink_mode_i, .gate_o(gate)
  );

  assign en = ready & ~oe_ni;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    led_channel u_ch (
      .cnt_i(cnt), .bright_i(bright_i[i*BR_W +: BR_W]),
      .gate_i(gate), .en_i(en), .led_o(led_o[i])
    );
  end
endmodule

// File: rtl/led_dimmer_chk.sv
module led_dimmer_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CH*8-1:0]      bright_i,
  input logic                   sleep_i,
  input logic                   oe_ni,
  input logic                   ready,
  input logic                   tick,
  input logic [7:0]             cnt,
  input logic [N_CH-1:0]        led_o
);
  logic [N_CH-1:0] nz;
  always_comb
    for (int i = 0; i < N_CH; i++) nz[i] = |bright_i[i*8 +: 8];

  p_oe_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (led_o == '0));

  p_zero_code_dark_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((led_o & ~nz) == '0));

  p_sleep_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (led_o == '0));

  p_wake_dark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (led_o == '0));

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !sleep_i) |=> (cnt == 8'($past(cnt) + 1)));

  p_reset_dark_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (led_o == '0));
endmodule

bind led_dimmer_top led_dimmer_chk #(.N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bright_i(bright_i), .sleep_i(sleep_i),
  .oe_ni(oe_ni), .ready(ready), .tick(tick), .cnt(cnt), .led_o(led_o)
);

// File: tb/led_dimmer_top_tb.sv
module led_dimmer_top_tb;
  localparam int N_CH = 8;
  localparam int DIV  = 2;
  localparam int BASE = 2;
  localparam int WAKE = 40;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_CH*8-1:0] bright_i = '0;
  logic [7:0]        grp_duty_i = 8'hFF, grp_period_i = 8'd0;
  logic              blink_mode_i = 1'b0, sleep_i = 1'b0, oe_ni = 1'b0;
  logic [N_CH-1:0]   led_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_wake, m_pre, m_cnt, m_dim, m_bpre, m_phase;

  led_dimmer_top #(.N_CH(N_CH), .DIV(DIV), .BLINK_BASE(BASE), .WAKE_CYC(WAKE)) u_dut (
    .clk_i, .rst_ni, .bright_i, .grp_duty_i, .grp_period_i,
    .blink_mode_i, .sleep_i, .oe_ni, .led_o
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_wake = 0; m_pre = 0; m_cnt = 0; m_dim = 0; m_bpre = 0; m_phase = 0;
    end else begin
      bit rdy, tk, wr;
      rdy = (m_wake == WAKE);
      if (sleep_i || !rdy) begin
        m_pre = 0; m_cnt = 0; m_dim = 0; m_bpre = 0; m_phase = 0;
      end else begin
        tk = (m_pre == DIV-1);
        m_pre = tk ? 0 : m_pre + 1;
        if (tk) begin
          wr = (m_cnt == 255);
          m_cnt = (m_cnt + 1) % 256;
          if (wr) begin
            m_dim = (m_dim + 1) % 256;
            if (m_bpre == BASE-1) begin
              m_bpre = 0;
              m_phase = (m_phase >= grp_period_i) ? 0 : m_phase + 1;
            end else m_bpre = m_bpre + 1;
          end
        end
      end
      if (sleep_i) m_wake = 0;
      else if (m_wake < WAKE) m_wake = m_wake + 1;
    end
  end

  function automatic logic [N_CH-1:0] exp_led();
    logic [N_CH-1:0] r;
    bit gate;
    if (blink_mode_i) gate = (m_phase * 256) < (int'(grp_duty_i) * (int'(grp_period_i) + 1));
    else              gate = m_dim < grp_duty_i;
    for (int i = 0; i < N_CH; i++)
      r[i] = !oe_ni && (m_wake == WAKE) && gate && (m_cnt < bright_i[i*8 +: 8]);
    return r;
  endfunction

  function automatic string tag_now();
    if (!rst_ni)             return "R1";
    if (oe_ni)               return "R7";
    if (m_wake != WAKE)      return "R9";
    if (blink_mode_i)        return "R5";
    return "R4/R6";
  endfunction

  task automatic check(string tag, logic [N_CH-1:0] act, logic [N_CH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: led_o=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic step_check();
    @(negedge clk_i);
    check(tag_now(), led_o, exp_led());
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: cycle %0d expected completion", cyc);
      summary();
    end
  end

  initial begin
    int unsigned seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    bright_i = {N_CH{8'h80}};
    repeat (3) begin
      @(negedge clk_i);
      check("R1", led_o, '0);
    end
    rst_ni = 1'b1;
    // R9: dark through the wake window
    repeat (WAKE + 2) step_check();

    // R3 / R2: lit-cycle count over one fast period with gate always open
    blink_mode_i = 1'b1; grp_period_i = 8'd0; grp_duty_i = 8'hFF;
    bright_i = '0;
    bright_i[7:0] = 8'd128; bright_i[15:8] = 8'd1; bright_i[23:16] = 8'd255;
    begin
      int c0 = 0, c1 = 0, c2 = 0, c3 = 0;
      for (int k = 0; k < 256*DIV; k++) begin
        step_check();
        c0 += led_o[0]; c1 += led_o[1]; c2 += led_o[2]; c3 += led_o[3];
      end
      check("R3", N_CH'(c0), N_CH'(128*DIV));
      check("R3", N_CH'(c1), N_CH'(1*DIV));
      check("R3", N_CH'(c2 / DIV), N_CH'(255));
      check("R2", N_CH'(c3), '0);
    end

    // R7: oe blanks immediately
    bright_i = {N_CH{8'hFF}};
    @(negedge clk_i); oe_ni = 1'b1; #1;
    check("R7", led_o, '0);
    oe_ni = 1'b0;

    // R8 then R9: sleep blanks after one edge, wake restarts dark
    @(negedge clk_i); sleep_i = 1'b1;
    step_check(); check("R8", led_o, '0);
    repeat (5) step_check();
    sleep_i = 1'b0;
    repeat (WAKE + 4) step_check();

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      for (int i = 0; i < N_CH; i++) bright_i[i*8 +: 8] = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 5) == 0) bright_i[8*($urandom_range(0, N_CH-1)) +: 8] = 8'd0;
      grp_duty_i   = 8'($urandom_range(0, 255));
      grp_period_i = 8'($urandom_range(0, 3));
      blink_mode_i = 1'($urandom_range(0, 1));
      if (ph % 8 == 7) begin
        sleep_i = 1'b1;
        repeat (20) step_check();
        sleep_i = 1'b0;
      end
      for (int k = 0; k < 2800; k++) begin
        step_check();
        if (k % 100 == 50) begin
          oe_ni = ($urandom_range(0, 9) == 0);
          // R6: period moves freely; in dimming mode it must not matter
          grp_period_i = 8'($urandom_range(0, blink_mode_i ? 3 : 255));
          bright_i[8*($urandom_range(0, N_CH-1)) +: 8] = 8'($urandom_range(0, 255));
        end
      end
    end
    done = 1;
    summary();
  end
endmodule